// File: doc/BRIEF.md
# Quarter-Rate Monochrome Raster Scanout

This block scans a 200 x 150 one-bit bitmap onto an 800 x 600, 60 Hz monitor. It runs from a fast system clock with a pixel enable that ticks at 10 MHz, which is a quarter of the 40 MHz dot rate that mode expects. Each enable tick therefore spans four screen dots. Each bitmap row is also repeated on four scan lines, so every logical pixel shows as a 4 x 4 dot block.

The horizontal position counter runs one 8-pixel cell ahead of the pixel on the screen. As a result, the video-memory byte address for a cell is on the bus a whole cell before that cell is shown. The sync windows are moved by the same amount. The three low bits of the position counter split every cell into fixed phases. Phase 0 is the scanout read slot, where the byte is captured. Phase 4 is a slot in which an external writer may use the memory. Phase 7 moves the captured byte into a shift register, which sends it out most significant bit first over the next eight ticks.

The block drives the sync pulses, the pixel bit, the byte address and the two slot strobes. The video memory lies outside the block and must return the addressed byte within the same enable period.

Top module: `qvga_scanout`

## Requirements
- R1: The horizontal position (hpos) counts 0 to 263 and then wraps. The line counter counts 0 to 627, advances when hpos wraps, and wraps after 627. Both counters move only on clocks where pix_en is high. While pix_en is low, every output holds its value.
- R2: hsync is high exactly while hpos is 218 to 249. This is 32 ticks, matching displayed pixels 210 to 241. hsync is low at all other times.
- R3: vsync is high exactly on lines 601 to 604 and low on all other lines.
- R4: While hpos < 200 and line < 600, vram_addr = (line/4)*25 + hpos/8, so one bitmap row serves four consecutive lines. At all other times vram_addr is 0.
- R5: fetch_slot is high when hpos%8 == 0, hpos < 200 and line < 600. host_slot is high whenever hpos%8 == 4, on every line including blanking. The two are never high together.
- R6: vram_rdata is captured on the enable tick in which fetch_slot is high.
- R7: The byte captured at hpos 8c is shown during hpos 8c+8 to 8c+15 of the same line. At hpos 8c+8+j, pix_out carries bit 7-j of that byte, so bit 7 comes first.
- R8: pix_out is 0 whenever hpos < 8, hpos >= 208 or line >= 600, whatever vram_rdata carries.
- R9: While rst_n is low, the outputs are: hsync 0, vsync 0, pix_out 0, vram_addr 0, fetch_slot 1 and host_slot 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Quarter-rate pixel tick enable |
| vram_rdata | input | 8 | Byte returned by video memory for vram_addr |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| pix_out | output | 1 | Monochrome pixel bit |
| vram_addr | output | 12 | Byte address of the cell being fetched |
| fetch_slot | output | 1 | Scanout read phase of the cell |
| host_slot | output | 1 | External write phase of the cell |

## Verification
The syncs, the address and the two slot strobes are decoded from the counters. They therefore take their new values one clock after the enable tick that moves the counters, with no further delay. A pixel appears eight enable ticks after its byte was captured, one tick after the phase-7 load. The bench holds a behavioural model of the position, the line and the bytes captured per cell. It advances the model only for ticks that the design will sample on the next rising edge, and it compares every output at the falling edge. Irregular enable gaps in the first lines check the hold behaviour. A full frame at the full tick rate then covers both sync windows and the wraps.

// File: rtl/qvga_pkg.sv
package qvga_pkg;

   // Per-tick control of the pixel shifter
   typedef struct packed {
      logic capture;   // latch memory byte (read slot)
      logic load;      // move latched byte into shifter (last phase of cell)
   } shift_ctl_t;

   function automatic bit is_pow2(input int unsigned n);
      return (n != 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/qvga_span_counter.sv
module qvga_span_counter #(
   parameter int unsigned SPAN = 264,
   localparam int unsigned W = $clog2(SPAN)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   output logic [W-1:0] count,
   output logic         last
);

   localparam logic [W-1:0] TOP = W'(SPAN - 1);

   generate
      if (SPAN < 2) begin : g_bad_span
         $error("qvga_span_counter: SPAN must be at least 2");
      end
   endgenerate

   assign last = (count == TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      count <= '0;
      else if (step)   count <= last ? '0 : count + 1'b1;
   end

   AST_CNT_IN_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
      count <= TOP); // R1
   AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (step && last) |=> (count == '0)); // R1
   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(count)); // R1

endmodule

// File: rtl/qvga_cell_sequencer.sv
module qvga_cell_sequencer #(
   parameter int unsigned H_VIS   = 200,
   parameter int unsigned V_VIS   = 600,
   parameter int unsigned CELL    = 8,
   parameter int unsigned ROW_REP = 4,
   parameter int unsigned HW      = 9,
   parameter int unsigned VW      = 10,
   parameter int unsigned ADDR_W  = 12
) (
   input  logic [HW-1:0]     hcnt,
   input  logic [VW-1:0]     vcnt,
   output logic [ADDR_W-1:0] vram_addr,
   output logic              fetch_slot,
   output logic              host_slot,
   output logic              load_cell,
   output logic              disp_vis
);

   localparam int unsigned CELL_BITS   = $clog2(CELL);
   localparam int unsigned COLS        = H_VIS / CELL;
   localparam int unsigned FETCH_PHASE = 0;
   localparam int unsigned HOST_PHASE  = CELL / 2;
   localparam int unsigned LOAD_PHASE  = CELL - 1;
   localparam int unsigned LEAD        = CELL;

   logic [CELL_BITS-1:0] phase;
   logic                 h_fetch_zone;
   logic                 v_active;
   logic [VW-1:0]        row;
   logic [HW-1:0]        col;

   assign phase        = hcnt[CELL_BITS-1:0];
   assign h_fetch_zone = hcnt < HW'(H_VIS);
   assign v_active     = vcnt < VW'(V_VIS);
   assign col          = hcnt >> CELL_BITS;

   // Row index: shift when the repeat factor allows it, divide otherwise
   generate
      if (qvga_pkg::is_pow2(ROW_REP)) begin : g_row_shift
         assign row = vcnt >> $clog2(ROW_REP);
      end else begin : g_row_div
         assign row = vcnt / VW'(ROW_REP);
      end
   endgenerate

   always_comb begin
      if (h_fetch_zone && v_active)
         vram_addr = ADDR_W'(row) * ADDR_W'(COLS) + ADDR_W'(col);
      else
         vram_addr = '0;
   end

   assign fetch_slot = h_fetch_zone && v_active && (phase == CELL_BITS'(FETCH_PHASE));
   assign host_slot  = (phase == CELL_BITS'(HOST_PHASE));
   assign load_cell  = h_fetch_zone && v_active && (phase == CELL_BITS'(LOAD_PHASE));
   assign disp_vis   = (hcnt >= HW'(LEAD)) && (hcnt < HW'(H_VIS + LEAD)) && v_active;

endmodule

// File: rtl/qvga_pixel_shifter.sv
module qvga_pixel_shifter #(
   parameter int unsigned CELL = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  step,
   input  qvga_pkg::shift_ctl_t  ctl,
   input  logic [CELL-1:0]       rdata,
   input  logic                  show,
   output logic                  pix
);

   logic [CELL-1:0] fetch_buf;
   logic [CELL-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fetch_buf <= '0;
      end else if (step && ctl.capture) begin
         fetch_buf <= rdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr <= '0;
      end else if (step) begin
         if (ctl.load) sr <= fetch_buf;
         else          sr <= {sr[CELL-2:0], 1'b0};
      end
   end

   assign pix = show & sr[CELL-1];

   AST_CAPTURE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (step && ctl.capture) |=> (fetch_buf == $past(rdata))); // R6
   AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(sr)); // R7
   AST_CTL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(ctl.capture && ctl.load)); // R5

endmodule

// File: rtl/qvga_scanout.sv
module qvga_scanout #(
   parameter int unsigned H_VIS            = 200,
   parameter int unsigned H_FP             = 10,
   parameter int unsigned H_SYNC           = 32,
   parameter int unsigned H_BP             = 22,
   parameter int unsigned V_VIS            = 600,
   parameter int unsigned V_FP             = 1,
   parameter int unsigned V_SYNC           = 4,
   parameter int unsigned V_BP             = 23,
   parameter int unsigned CELL             = 8,
   parameter int unsigned ROW_REP          = 4,
   parameter bit          SYNC_ACTIVE_HIGH = 1'b1,
   localparam int unsigned ADDR_W = $clog2((H_VIS / CELL) * (V_VIS / ROW_REP))
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pix_en,
   input  logic [CELL-1:0]   vram_rdata,
   output logic              hsync,
   output logic              vsync,
   output logic              pix_out,
   output logic [ADDR_W-1:0] vram_addr,
   output logic              fetch_slot,
   output logic              host_slot
);

   localparam int unsigned H_TOTAL  = H_VIS + H_FP + H_SYNC + H_BP;
   localparam int unsigned V_TOTAL  = V_VIS + V_FP + V_SYNC + V_BP;
   localparam int unsigned HW       = $clog2(H_TOTAL);
   localparam int unsigned VW       = $clog2(V_TOTAL);
   localparam int unsigned COLS     = H_VIS / CELL;
   localparam int unsigned ROWS     = V_VIS / ROW_REP;
   localparam int unsigned LEAD     = CELL;
   localparam int unsigned HS_START = H_VIS + LEAD + H_FP;
   localparam int unsigned HS_END   = HS_START + H_SYNC;
   localparam int unsigned VS_START = V_VIS + V_FP;
   localparam int unsigned VS_END   = VS_START + V_SYNC;

   // Elaboration-time parameter checks
   generate
      if (!qvga_pkg::is_pow2(CELL) || CELL < 2) begin : g_bad_cell
         $error("qvga_scanout: CELL must be a power of two, at least 2");
      end
      if (H_VIS % CELL != 0) begin : g_bad_hvis
         $error("qvga_scanout: H_VIS must be a whole number of cells");
      end
      if (ROW_REP == 0 || V_VIS % ROW_REP != 0) begin : g_bad_rep
         $error("qvga_scanout: V_VIS must be a whole number of repeated rows");
      end
      if (HS_END > H_TOTAL) begin : g_bad_hsync
         $error("qvga_scanout: shifted sync window exceeds the line");
      end
      if (VS_END > V_TOTAL) begin : g_bad_vsync
         $error("qvga_scanout: vertical sync window exceeds the frame");
      end
   endgenerate

   logic [HW-1:0]        hcnt;
   logic [VW-1:0]        vcnt;
   logic                 h_last;
   logic                 v_last;
   logic                 load_cell;
   logic                 disp_vis;
   logic                 hsync_raw;
   logic                 vsync_raw;
   qvga_pkg::shift_ctl_t sh_ctl;

   qvga_span_counter #(.SPAN(H_TOTAL)) u_hctr (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (pix_en),
      .count (hcnt),
      .last  (h_last)
   );

   qvga_span_counter #(.SPAN(V_TOTAL)) u_vctr (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (pix_en & h_last),
      .count (vcnt),
      .last  (v_last)
   );

   qvga_cell_sequencer #(
      .H_VIS   (H_VIS),
      .V_VIS   (V_VIS),
      .CELL    (CELL),
      .ROW_REP (ROW_REP),
      .HW      (HW),
      .VW      (VW),
      .ADDR_W  (ADDR_W)
   ) u_seq (
      .hcnt       (hcnt),
      .vcnt       (vcnt),
      .vram_addr  (vram_addr),
      .fetch_slot (fetch_slot),
      .host_slot  (host_slot),
      .load_cell  (load_cell),
      .disp_vis   (disp_vis)
   );

   assign sh_ctl.capture = fetch_slot;
   assign sh_ctl.load    = load_cell;

   qvga_pixel_shifter #(.CELL(CELL)) u_shift (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (pix_en),
      .ctl   (sh_ctl),
      .rdata (vram_rdata),
      .show  (disp_vis),
      .pix   (pix_out)
   );

   assign hsync_raw = (hcnt >= HW'(HS_START)) && (hcnt < HW'(HS_END));
   assign vsync_raw = (vcnt >= VW'(VS_START)) && (vcnt < VW'(VS_END));

   generate
      if (SYNC_ACTIVE_HIGH) begin : g_sync_hi
         assign hsync = hsync_raw;
         assign vsync = vsync_raw;
      end else begin : g_sync_lo
         assign hsync = ~hsync_raw;
         assign vsync = ~vsync_raw;
      end
   endgenerate

   AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_en && h_last && v_last) |=> (vcnt == '0 && hcnt == '0)); // R1
   AST_HSYNC_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hsync_raw) |-> $past(pix_en)); // R2
   AST_VSYNC_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      vsync_raw |-> !fetch_slot); // R3
   AST_ADDR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_slot |-> (vram_addr < ADDR_W'(COLS * ROWS))); // R4
   AST_SLOT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(fetch_slot && host_slot)); // R5
   AST_HSYNC_DARK: assert property (@(posedge clk) disable iff (!rst_n)
      hsync_raw |-> !pix_out); // R8

endmodule

// File: tb/tb_qvga_scanout.sv
module tb_qvga_scanout;

   localparam int HT = 264;
   localparam int VT = 628;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pix_en = 1'b0;
   logic [7:0]  vram_rdata;
   logic        hsync, vsync, pix_out, fetch_slot, host_slot;
   logic [11:0] vram_addr;

   int  checks = 0;
   int  fails  = 0;
   bit  done   = 1'b0;
   int  h = 0;
   int  v = 0;
   logic [7:0] cellbuf [0:24];

   always #10 clk = ~clk;   // 50 MHz

   function automatic logic [7:0] mem_at(input int a);
      return 8'((a * 73) ^ (a >> 3) ^ 8'hA5);
   endfunction

   // Behavioural video memory: returns the byte for the presented address
   assign vram_rdata = mem_at(int'(vram_addr));

   qvga_scanout dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .pix_en     (pix_en),
      .vram_rdata (vram_rdata),
      .hsync      (hsync),
      .vsync      (vsync),
      .pix_out    (pix_out),
      .vram_addr  (vram_addr),
      .fetch_slot (fetch_slot),
      .host_slot  (host_slot)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s at h=%0d v=%0d actual=%0d expected=%0d", tag, h, v, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   // Compare every output with the model state (h, v)
   task automatic check_now();
      int  e_addr;
      bit  e_hs, e_vs, e_fetch, e_host, e_pix, vis;
      e_hs    = (h >= 218 && h < 250);
      e_vs    = (v >= 601 && v < 605);
      e_addr  = (h < 200 && v < 600) ? (v / 4) * 25 + h / 8 : 0;
      e_fetch = (h % 8 == 0) && h < 200 && v < 600;
      e_host  = (h % 8 == 4);
      vis     = (h >= 8 && h < 208 && v < 600);
      e_pix   = vis ? cellbuf[(h - 8) / 8][7 - ((h - 8) % 8)] : 1'b0;
      chk(hsync == e_hs, "R2 hsync", int'(hsync), int'(e_hs));
      chk(vsync == e_vs, "R3 vsync", int'(vsync), int'(e_vs));
      chk(int'(vram_addr) == e_addr, "R1 R4 vram_addr", int'(vram_addr), e_addr);
      chk(fetch_slot == e_fetch && host_slot == e_host, "R5 slots",
          int'({fetch_slot, host_slot}), int'({e_fetch, e_host}));
      if (vis) chk(pix_out == e_pix, "R6 R7 pix_out", int'(pix_out), int'(e_pix));
      else     chk(pix_out == 1'b0, "R8 pix_out blank", int'(pix_out), 0);
   endtask

   initial begin
      int  ticks;
      bit  en;
      for (int i = 0; i < 25; i++) cellbuf[i] = 8'h00;
      rst_n  = 1'b0;
      pix_en = 1'b0;
      repeat (5) @(negedge clk);
      // R9: reset state
      chk(hsync == 1'b0, "R9 hsync", int'(hsync), 0);
      chk(vsync == 1'b0, "R9 vsync", int'(vsync), 0);
      chk(pix_out == 1'b0, "R9 pix_out", int'(pix_out), 0);
      chk(vram_addr == '0, "R9 vram_addr", int'(vram_addr), 0);
      chk(fetch_slot == 1'b1, "R9 fetch_slot", int'(fetch_slot), 1);
      chk(host_slot == 1'b0, "R9 host_slot", int'(host_slot), 0);
      rst_n = 1'b1;
      ticks = 0;
      for (int k = 0; ticks < HT * VT + 600; k++) begin
         check_now();
         // irregular enable gaps early on exercise the hold behaviour (R1)
         en = (k < 3000) ? ((k % 7) != 3 && (k % 11) != 6) : 1'b1;
         pix_en = en;
         if (en) begin
            ticks++;
            if (h % 8 == 0 && h < 200 && v < 600)
               cellbuf[h / 8] = mem_at((v / 4) * 25 + h / 8);   // R6 capture
            h++;
            if (h == HT) begin
               h = 0;
               v++;
               if (v == VT) v = 0;
            end
         end
         @(negedge clk);
      end
      check_now();
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (199000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
         summary();
         $finish;
      end
   end

endmodule